// File: doc/BRIEF.md
# SIMD Warp Issue Sequencer

This block decides which warp a streaming multiprocessor issues next and spreads that warp's instruction across a narrow row of processing lanes. It keeps one program counter for each resident warp. At each instruction boundary it picks one of the warps that reports itself ready. It then spends several consecutive cycles ("beats") stepping the warp's threads through the lanes, one group of threads per beat. After that it advances the warp's program counter and picks again.

A warp that is stalled on memory simply holds its ready flag low. The arbiter passes over it and another warp issues, so latency is hidden by switching between warps. Threads that are switched off by conditional execution still take their lane slot; their lane enable is just held low. With the default parameters there are 24 warps of 32 threads on 8 lanes, so each instruction takes 4 beats.

Top module: `warp_issue_seq`

## Requirements
- R1: After reset no instruction is issued: `issue_valid` is 0 and `lane_en` is all zero. Every warp's PC is 0.
- R2: A warp is chosen only at an instruction boundary, which means the sequencer is idle or on its last beat. If no warp is ready at that edge, the sequencer goes idle on the next cycle: `issue_valid` is 0 and `lane_en` is 0.
- R3: An issued instruction occupies exactly BEATS = THREADS/LANES consecutive cycles (4 by default). During those cycles `issue_valid` is 1, `issue_warp` is constant, and `issue_beat` counts 0, 1, …, BEATS-1.
- R4: On beat k, lane j carries thread k·LANES + j. `lane_en` bit j equals bit k·LANES + j of the issued warp's active mask. The mask of warp w sits at bits w·THREADS and up of `warp_mask`.
- R5: The active mask is captured at the edge that selects the warp. Changes to `warp_mask` while that instruction is being issued do not affect its `lane_en`.
- R6: Selection is round robin. The next warp is the first ready warp found by searching upward from the warp issued last, wrapping from NUM_WARPS-1 to 0. Directly after reset the search starts at warp 0. The last-issued warp is chosen again only when no other warp is ready.
- R7: Changes to `warp_ready` during beats other than the last do not cut short or change the instruction in progress.
- R8: `issue_pc` shows the selected warp's PC on every beat. That PC increases by PC_STEP (4) after the warp's last beat. The PCs of other warps do not change.
- R9: A warp whose active mask is all zero still issues for a full BEATS cycles with `issue_valid` 1 and `lane_en` 0, and its PC still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| warp_ready | input | NUM_WARPS | Per-warp flag: warp can issue |
| warp_mask | input | NUM_WARPS*THREADS | Per-warp active-thread masks, warp w at [w*THREADS +: THREADS] |
| issue_valid | output | 1 | A beat is being issued this cycle |
| issue_warp | output | clog2(NUM_WARPS) | Warp being issued |
| issue_beat | output | clog2(BEATS) | Beat index, selects thread group |
| lane_en | output | LANES | Per-lane thread enables for this beat |
| issue_pc | output | PC_W | PC of the warp being issued |

## Verification
The bench checks the search order of the arbiter at both ends of the warp range. It starts the search just past warp 5 and again just past warp 23. A design that searched from index 0, or failed to wrap, would pick warp 1 before warp 5 or skip warp 0. Ready and mask inputs are changed in the middle of an instruction. A sequencer that re-arbitrated on every beat, or read the mask live, would switch warps or show the new enables before beat 3 completes. A warp with an all-zero mask is issued twice in a row. A design that skipped empty warps, or did not advance their PC, would show no issue cycles or the same PC twice.

// File: rtl/wis_pkg.sv
package wis_pkg;

   // index width that never collapses to zero bits
   function automatic int unsigned idx_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   typedef enum logic {
      SEQ_IDLE  = 1'b0,
      SEQ_ISSUE = 1'b1
   } seq_state_e;

endpackage

// File: rtl/wis_rr_pick.sv
module wis_rr_pick
   import wis_pkg::*;
#(
   parameter int unsigned N = 24,
   localparam int unsigned W = idx_w(N)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   input  logic [W-1:0] last,
   output logic         gnt_valid,
   output logic [W-1:0] gnt_idx
);

   always_comb begin
      gnt_valid = |req;
      gnt_idx   = '0;
      // walk downward so the nearest candidate after 'last' wins
      for (int i = N; i >= 1; i--) begin
         logic [W:0] cand;
         cand = {1'b0, last} + (W+1)'(i);
         if (cand >= (W+1)'(N)) cand = cand - (W+1)'(N);
         if (req[cand[W-1:0]]) gnt_idx = cand[W-1:0];
      end
   end

   // R6
   grant_is_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid |-> req[gnt_idx]);

   // R6
   grant_skips_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(req) > 1) |-> (gnt_idx != last));

endmodule

// File: rtl/wis_pc_file.sv
module wis_pc_file
   import wis_pkg::*;
#(
   parameter int unsigned N       = 24,
   parameter int unsigned PC_W    = 16,
   parameter int unsigned PC_STEP = 4,
   localparam int unsigned W = idx_w(N)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            adv,
   input  logic [W-1:0]    adv_idx,
   input  logic [W-1:0]    rd_idx,
   output logic [PC_W-1:0] rd_pc
);

   logic [PC_W-1:0] pc_q [N];

   for (genvar g = 0; g < N; g++) begin : g_ctx
      always_ff @(posedge clk) begin
         if (!rst_n)                               pc_q[g] <= '0;
         else if (adv && adv_idx == W'(g))         pc_q[g] <= pc_q[g] + PC_W'(PC_STEP);
      end

      // R8
      pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(adv && adv_idx == W'(g)) |=> $stable(pc_q[g]));
   end

   assign rd_pc = pc_q[rd_idx];

endmodule

// File: rtl/wis_lane_slice.sv
module wis_lane_slice
   import wis_pkg::*;
#(
   parameter int unsigned THREADS = 32,
   parameter int unsigned LANES   = 8,
   localparam int unsigned BEATS  = THREADS / LANES,
   localparam int unsigned BW     = idx_w(BEATS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [THREADS-1:0] mask_in,
   input  logic [BW-1:0]      beat,
   input  logic               en,
   output logic [LANES-1:0]   lane_en
);

   logic [THREADS-1:0] mask_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    mask_q <= '0;
      else if (load) mask_q <= mask_in;
   end

   if (BEATS == 1) begin : g_wide
      assign lane_en = en ? mask_q[LANES-1:0] : '0;
   end else begin : g_beats
      assign lane_en = en ? mask_q[int'(beat)*LANES +: LANES] : '0;
   end

   // R5
   mask_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(mask_q));

endmodule

// File: rtl/warp_issue_seq.sv
module warp_issue_seq
   import wis_pkg::*;
#(
   parameter int unsigned NUM_WARPS = 24,
   parameter int unsigned THREADS   = 32,
   parameter int unsigned LANES     = 8,
   parameter int unsigned PC_W      = 16,
   parameter int unsigned PC_STEP   = 4,
   localparam int unsigned BEATS    = THREADS / LANES,
   localparam int unsigned WW       = idx_w(NUM_WARPS),
   localparam int unsigned BW       = idx_w(BEATS)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_WARPS-1:0]         warp_ready,
   input  logic [NUM_WARPS*THREADS-1:0] warp_mask,
   output logic                         issue_valid,
   output logic [WW-1:0]                issue_warp,
   output logic [BW-1:0]                issue_beat,
   output logic [LANES-1:0]             lane_en,
   output logic [PC_W-1:0]              issue_pc
);

   if (THREADS % LANES != 0) begin : g_bad_split
      $error("THREADS must be a multiple of LANES");
   end
   if (NUM_WARPS < 1 || LANES < 1) begin : g_bad_size
      $error("NUM_WARPS and LANES must be at least 1");
   end
   if (PC_STEP == 0) begin : g_bad_step
      $error("PC_STEP must be nonzero");
   end

   seq_state_e      state_q;
   logic [WW-1:0]   cur_q;
   logic [BW-1:0]   beat_q;
   logic            busy, last_beat, boundary;
   logic            gnt_valid;
   logic [WW-1:0]   gnt_idx;

   assign busy      = (state_q == SEQ_ISSUE);
   assign last_beat = (beat_q == BW'(BEATS-1));
   assign boundary  = !busy || last_beat;

   wis_rr_pick #(.N(NUM_WARPS)) i_pick (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (warp_ready),
      .last      (cur_q),
      .gnt_valid (gnt_valid),
      .gnt_idx   (gnt_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         cur_q   <= WW'(NUM_WARPS-1);
         beat_q  <= '0;
      end else if (boundary) begin
         beat_q <= '0;
         if (gnt_valid) begin
            state_q <= SEQ_ISSUE;
            cur_q   <= gnt_idx;
         end else begin
            state_q <= SEQ_IDLE;
         end
      end else begin
         beat_q <= beat_q + BW'(1);
      end
   end

   wis_pc_file #(.N(NUM_WARPS), .PC_W(PC_W), .PC_STEP(PC_STEP)) i_pcs (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (busy && last_beat),
      .adv_idx (cur_q),
      .rd_idx  (cur_q),
      .rd_pc   (issue_pc)
   );

   wis_lane_slice #(.THREADS(THREADS), .LANES(LANES)) i_lanes (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (boundary && gnt_valid),
      .mask_in (warp_mask[int'(gnt_idx)*THREADS +: THREADS]),
      .beat    (beat_q),
      .en      (busy),
      .lane_en (lane_en)
   );

   assign issue_valid = busy;
   assign issue_warp  = cur_q;
   assign issue_beat  = beat_q;

   // R3
   beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && issue_beat != BW'(BEATS-1)) |=>
         (issue_valid && issue_beat == $past(issue_beat) + BW'(1)));

   // R7
   warp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && issue_beat != BW'(BEATS-1)) |=> $stable(issue_warp));

   // R2
   idle_when_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((!issue_valid || issue_beat == BW'(BEATS-1)) && warp_ready == '0) |=> !issue_valid);

   // R1
   no_lanes_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_valid |-> (lane_en == '0));

   // R3
   first_beat_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(issue_valid) |-> (issue_beat == '0));

endmodule

// File: tb/test_warp_issue_seq.sv
module test_warp_issue_seq;

   localparam int NW = 24;
   localparam int TH = 32;
   localparam int LN = 8;
   localparam int NB = TH / LN;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NW-1:0]     ready = '0;
   logic [NW*TH-1:0]  mask_bus;
   logic              issue_valid;
   logic [4:0]        issue_warp;
   logic [1:0]        issue_beat;
   logic [LN-1:0]     lane_en;
   logic [15:0]       issue_pc;

   logic [TH-1:0]     m [NW];
   int                pcs [NW];
   int                checks = 0;
   int                errors = 0;
   bit                done = 0;

   always #10 clk = ~clk;   // 50 MHz

   always_comb
      for (int w = 0; w < NW; w++) mask_bus[w*TH +: TH] = m[w];

   warp_issue_seq i_warp_issue_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .warp_ready  (ready),
      .warp_mask   (mask_bus),
      .issue_valid (issue_valid),
      .issue_warp  (issue_warp),
      .issue_beat  (issue_beat),
      .lane_en     (lane_en),
      .issue_pc    (issue_pc)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic check_beat(input int w, input int b, input logic [TH-1:0] snap,
                             input string req);
      check(issue_valid == 1'b1, req, "valid", issue_valid, 1);
      check(issue_warp == 5'(w), req, "warp", issue_warp, w);
      check(issue_beat == 2'(b), req, "beat", issue_beat, b);
      check(lane_en == snap[b*LN +: LN], req, "lane_en", lane_en, snap[b*LN +: LN]);
      check(issue_pc == 16'(pcs[w]), req, "pc", issue_pc, pcs[w]);
   endtask

   // called on a negedge; checks the next full instruction
   task automatic expect_instr(input int w, input string req);
      logic [TH-1:0] snap = m[w];
      for (int b = 0; b < NB; b++) begin
         @(negedge clk);
         check_beat(w, b, snap, req);
      end
      pcs[w] += 4;
   endtask

   task automatic expect_idle(input string req);
      @(negedge clk);
      check(issue_valid == 1'b0, req, "idle valid", issue_valid, 0);
      check(lane_en == '0, req, "idle lane_en", lane_en, 0);
   endtask

   task automatic t_reset;
      // R1
      check(issue_valid == 1'b0, "R1", "reset valid", issue_valid, 0);
      check(lane_en == '0, "R1", "reset lane_en", lane_en, 0);
      repeat (2) expect_idle("R2");
   endtask

   task automatic t_single;
      // R3 R4 R8: one warp issues back to back, PC steps
      ready = NW'(1) << 3;
      expect_instr(3, "R4");
      expect_instr(3, "R8");
      ready = '0;
      expect_idle("R2");
   endtask

   task automatic t_round_robin;
      // R6: last issued was warp 3
      ready = (NW'(1) << 1) | (NW'(1) << 5) | (NW'(1) << 20);
      expect_instr(5, "R6");
      expect_instr(20, "R6");
      expect_instr(1, "R6");
      expect_instr(5, "R6");
      ready = '0;
      expect_idle("R2");
   endtask

   task automatic t_wrap;
      // R6: search wraps from the top warp to warp 0
      ready = (NW'(1) << 0) | (NW'(1) << 23);
      expect_instr(23, "R6");
      expect_instr(0, "R6");
      expect_instr(23, "R6");
      ready = '0;
      expect_idle("R2");
   endtask

   task automatic t_zero_mask;
      // R9
      ready = NW'(1) << 7;
      expect_instr(7, "R9");
      expect_instr(7, "R9");
      ready = '0;
      expect_idle("R2");
   endtask

   task automatic t_mid_change;
      logic [TH-1:0] snap;
      ready = NW'(1) << 9;
      snap = m[9];
      @(negedge clk);
      check_beat(9, 0, snap, "R3");
      ready = NW'(1) << 2;          // R7: warp 9 drops out mid-instruction
      m[9] = '1;                    // R5: mask change mid-instruction
      for (int b = 1; b < NB; b++) begin
         @(negedge clk);
         check_beat(9, b, snap, (b == 1) ? "R5" : "R7");
      end
      pcs[9] += 4;
      expect_instr(2, "R6");
      ready = '0;
      expect_idle("R2");
   endtask

   initial begin
      for (int w = 0; w < NW; w++) begin
         m[w] = 32'h9E37_79B9 * 32'(w + 1);
         pcs[w] = 0;
      end
      m[3] = 32'hA1B2_C3D4;
      m[7] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_round_robin();
      t_wrap();
      t_zero_mask();
      t_mid_change();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #4_000_000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual 0x0 expected 0x1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule